// File: doc/BRIEF.md
# Pending Fill Snoop Monitor

This block sits beside a cache controller on a split-transaction bus. While the cache has one of its own block reads, block writes, single-word writes, conditional writes or flushes outstanding, other devices can still issue packets to the same block. Such packets fall between the cache's request and the reply to it. The monitor keeps one address slot for this window. The cache's own request header arms the slot and the matching own reply disarms it.

While the slot is armed, the monitor compares every foreign header with the stored block address. A foreign block read to that block means another copy will exist. The monitor records a shared flag and pulses the bus shared line. A foreign single-word or conditional write request pulses the shared line only. A foreign write reply, conditional-write reply or block-write request means the data the cache will receive is out of date, so the monitor records a reply-stale flag. When the cache's own single-word write reply arrives, the monitor gives a merged shared value for the line-state update. Updating the line array and building reply packets are left to other logic.

Top module: `pend_snoop_mon`

## Requirements
- R1: After reset, `slot_valid`, `slot_shared`, `slot_stale`, `share_pull`, `merge_valid` and `merge_shared` are all 0.
- R2: Commands are 4 bits. Bit 0 is 1 for a reply. Codes: block read 0/1, block write 2/3, single write 4/5, conditional write 6/7, flush 8/9; codes 10 to 15 are other traffic. An own request with code 0, 2, 4, 6 or 8 stores the block address and sets `slot_valid`. It also clears `slot_shared` and `slot_stale`. These outputs show the change in the cycle after the header beat. Another own request re-arms the slot in the same way.
- R3: A header counts as own only when `hdr_src` equals `my_id`. Any other header is foreign, whatever its address.
- R4: A foreign block-read request (0) that hits the armed slot sets `slot_shared` and raises `share_pull` in the next cycle.
- R5: A foreign single-write (4) or conditional-write (6) request that hits the armed slot raises `share_pull` in the next cycle. It leaves `slot_shared` and `slot_stale` unchanged.
- R6: A foreign single-write reply (5), conditional-write reply (7) or block-write request (2) that hits the armed slot sets `slot_stale` in the next cycle.
- R7: An own reply with code 1, 3, 5 or 7 clears `slot_valid` in the next cycle. An own flush reply (9) and codes 10 to 15 leave it unchanged.
- R8: An own single-write reply (5) raises `merge_valid` for one cycle, in the cycle after the beat. In that cycle, `merge_shared` equals `hdr_reply_shared` ORed with the value `slot_shared` had at the beat.
- R9: A hit compares the address without its low `OFS_W` word-in-block bits. A header that differs only in those bits hits. A header that differs in any higher bit misses and has no effect.
- R10: A foreign header has no effect while the slot is disarmed. A header with `hdr_valid` low has no effect.
- R11: `share_pull` is high only in the cycle after a hitting header beat, and it is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header beat present this cycle |
| hdr_cmd | input | 4 | Command code (see R2) |
| hdr_src | input | ID_W | Device id of the packet sender |
| hdr_addr | input | ADDR_W | Word address in the header |
| hdr_reply_shared | input | 1 | Shared indication carried by a reply |
| my_id | input | ID_W | This cache's device id |
| share_pull | output | 1 | One-cycle pull of the bus shared line |
| slot_valid | output | 1 | Monitor armed |
| slot_shared | output | 1 | Sharing seen during the window |
| slot_stale | output | 1 | Pending reply is stale |
| merge_valid | output | 1 | Merged shared value is valid |
| merge_shared | output | 1 | Reply shared ORed with stored shared |

## Verification
The bench builds the block with a 16-bit address, a 4-bit id and 3 offset bits. With this small address space, directed headers and a long pseudo-random stream often hit the armed block, hit it at a different word, or miss it in only one upper bit. The small id field makes own packets and foreign packets both common in the random stream. This exercises arming, re-arming, stale and shared setting, and the merge path in many interleavings against the bench's own model.

// File: rtl/pend_snoop_mon.sv
module pend_snoop_mon #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 10,
  parameter int OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [3:0]        hdr_cmd,
  input  logic [ID_W-1:0]   hdr_src,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              hdr_reply_shared,
  input  logic [ID_W-1:0]   my_id,
  output logic              share_pull,
  output logic              slot_valid,
  output logic              slot_shared,
  output logic              slot_stale,
  output logic              merge_valid,
  output logic              merge_shared
);

  localparam int BLK_W = ADDR_W - OFS_W;

  localparam logic [3:0] C_RB_RQ = 4'd0, C_RB_RP = 4'd1;
  localparam logic [3:0] C_WB_RQ = 4'd2, C_WB_RP = 4'd3;
  localparam logic [3:0] C_WS_RQ = 4'd4, C_WS_RP = 4'd5;
  localparam logic [3:0] C_CW_RQ = 4'd6, C_CW_RP = 4'd7;
  localparam logic [3:0] C_FB_RQ = 4'd8;

  logic [BLK_W-1:0] slot_blk;
  logic own, hit;
  logic do_arm, do_disarm, do_share, do_pull, do_stale, do_merge;

  assign own = hdr_valid && (hdr_src == my_id);
  assign hit = hdr_valid && !own && slot_valid &&
               (hdr_addr[ADDR_W-1:OFS_W] == slot_blk);

  always_comb begin
    do_arm = 1'b0; do_disarm = 1'b0; do_share = 1'b0;
    do_pull = 1'b0; do_stale = 1'b0; do_merge = 1'b0;
    if (own) begin
      unique case (hdr_cmd)
        C_RB_RQ, C_WB_RQ, C_WS_RQ, C_CW_RQ, C_FB_RQ: do_arm = 1'b1;
        C_RB_RP, C_WB_RP, C_CW_RP: do_disarm = 1'b1;
        C_WS_RP: begin do_disarm = 1'b1; do_merge = 1'b1; end
        default: ;
      endcase
    end else if (hit) begin
      unique case (hdr_cmd)
        C_RB_RQ: begin do_share = 1'b1; do_pull = 1'b1; end
        C_WS_RQ, C_CW_RQ: do_pull = 1'b1;
        C_WS_RP, C_CW_RP, C_WB_RQ: do_stale = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_blk     <= '0;
      slot_valid   <= 1'b0;
      slot_shared  <= 1'b0;
      slot_stale   <= 1'b0;
      share_pull   <= 1'b0;
      merge_valid  <= 1'b0;
      merge_shared <= 1'b0;
    end else begin
      share_pull   <= do_pull;
      merge_valid  <= do_merge;
      merge_shared <= do_merge && (hdr_reply_shared || slot_shared);
      if (do_arm) begin
        slot_blk    <= hdr_addr[ADDR_W-1:OFS_W];
        slot_valid  <= 1'b1;
        slot_shared <= 1'b0;
        slot_stale  <= 1'b0;
      end else begin
        if (do_disarm) slot_valid  <= 1'b0;
        if (do_share)  slot_shared <= 1'b1;
        if (do_stale)  slot_stale  <= 1'b1;
      end
    end
  end

  // R11
  pull_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    share_pull |-> $past(slot_valid) && $past(hdr_valid));

  // R2
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_valid) |-> !slot_shared && !slot_stale);

  // R6
  stale_while_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_stale) |-> slot_valid);

  // R8
  merge_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_valid |-> merge_shared == ($past(hdr_reply_shared) || $past(slot_shared)));

  // R8
  merge_ends_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_valid |-> !slot_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hdr_valid) |-> $stable(slot_valid) && $stable(slot_shared) && $stable(slot_stale));

endmodule

// File: tb/pend_snoop_mon_tb.sv
module pend_snoop_mon_tb;
  localparam int AW = 16, IW = 4, OW = 3;
  localparam logic [IW-1:0] MYID = 4'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hv = 1'b0, rs = 1'b0;
  logic [3:0] cmd = '0;
  logic [IW-1:0] src = '0;
  logic [AW-1:0] addr = '0;
  logic pull, sv, ssh, sst, mv, ms;

  int checks = 0, errors = 0;
  int m_valid = 0, m_blk = 0, m_sh = 0, m_st = 0, m_pull = 0, m_mv = 0, m_ms = 0;

  always #10 clk = ~clk;

  pend_snoop_mon #(.ADDR_W(AW), .ID_W(IW), .OFS_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hv), .hdr_cmd(cmd), .hdr_src(src),
    .hdr_addr(addr), .hdr_reply_shared(rs), .my_id(MYID),
    .share_pull(pull), .slot_valid(sv), .slot_shared(ssh), .slot_stale(sst),
    .merge_valid(mv), .merge_shared(ms));

  task automatic model();
    int own, hit, c, old_sh;
    m_pull = 0; m_mv = 0; m_ms = 0;
    if (hv) begin
      c = int'(cmd);
      own = (src == MYID);
      hit = (m_valid != 0) && (int'(addr) / 8 == m_blk);
      old_sh = m_sh;
      if (own) begin
        if (c == 0 || c == 2 || c == 4 || c == 6 || c == 8) begin
          m_valid = 1; m_blk = int'(addr) / 8; m_sh = 0; m_st = 0;
        end else if (c == 1 || c == 3 || c == 7) m_valid = 0;
        else if (c == 5) begin
          m_valid = 0; m_mv = 1; m_ms = (rs || old_sh != 0) ? 1 : 0;
        end
      end else if (hit) begin
        if (c == 0) begin m_sh = 1; m_pull = 1; end
        else if (c == 4 || c == 6) m_pull = 1;
        else if (c == 5 || c == 7 || c == 2) m_st = 1;
      end
    end
  endtask

  task automatic chk(string r);
    checks++;
    if (int'(sv) != m_valid || int'(ssh) != m_sh || int'(sst) != m_st ||
        int'(pull) != m_pull || int'(mv) != m_mv || int'(ms) != m_ms) begin
      errors++;
      $display("FAIL %s: got v%0b s%0b st%0b p%0b mv%0b ms%0b exp v%0d s%0d st%0d p%0d mv%0d ms%0d",
               r, sv, ssh, sst, pull, mv, ms, m_valid, m_sh, m_st, m_pull, m_mv, m_ms);
    end
  endtask

  task automatic step(input logic v, input int c, input logic [IW-1:0] s,
                      input int a, input logic r, input string tag);
    hv = v; cmd = 4'(c); src = s; addr = AW'(a); rs = r;
    @(posedge clk);
    model();
    @(negedge clk);
    hv = 1'b0;
    chk(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 0, MYID, 0, 1'b0, tag);
  endtask

  localparam logic [IW-1:0] OTH = 4'd9;

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");

    step(1, 0, MYID, 16'h1234, 0, "R2 arm on own block read");
    step(1, 0, OTH, 16'h1231, 0, "R4 R9 foreign read other word");
    idle("R11 pull drops");
    step(1, 4, OTH, 16'h1237, 0, "R5 foreign single write req");
    step(1, 6, OTH, 16'h1230, 0, "R5 foreign cond write req");
    step(1, 0, OTH, 16'h1234, 0, "R11 back to back a");
    step(1, 0, OTH, 16'h1234, 0, "R11 back to back b");
    step(1, 5, OTH, 16'h1234, 0, "R6 foreign ws reply stale");
    step(1, 1, OTH, 16'h1234, 0, "R3 foreign read reply no disarm");
    step(1, 5, MYID, 16'h1234, 0, "R8 R7 own ws reply merge");
    step(1, 0, OTH, 16'h1234, 0, "R10 foreign when disarmed");
    step(0, 0, MYID, 16'h2000, 0, "R10 valid low ignored");
    step(1, 2, MYID, 16'h2000, 0, "R2 arm on own block write");
    step(1, 0, OTH, 16'h2008, 0, "R9 next block misses");
    step(1, 0, OTH, 16'hA000, 0, "R9 top bit misses");
    step(1, 7, OTH, 16'h2003, 0, "R6 foreign cw reply stale");
    step(1, 9, MYID, 16'h2000, 0, "R7 own flush reply keeps");
    step(1, 12, MYID, 16'h2000, 0, "R7 other traffic keeps");
    step(1, 3, MYID, 16'h2000, 0, "R7 own wb reply disarms");
    step(1, 4, MYID, 16'h3000, 0, "R2 arm on own single write");
    step(1, 5, MYID, 16'h3000, 1, "R8 merge from reply shared");
    step(1, 4, MYID, 16'h3000, 0, "R2 re-arm single write");
    step(1, 5, MYID, 16'h3000, 0, "R8 merge zero");
    step(1, 6, MYID, 16'h4000, 0, "R2 arm on own cond write");
    step(1, 2, OTH, 16'h4001, 0, "R6 foreign wb req stale");
    step(1, 6, MYID, 16'h4100, 0, "R2 re-arm clears stale");
    step(1, 7, MYID, 16'h4100, 0, "R7 own cw reply disarms");
    step(1, 8, MYID, 16'h5000, 0, "R2 arm on own flush");
    step(1, 1, MYID, 16'h5000, 0, "R7 own rb reply disarms");

    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [IW-1:0] s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = lfsr[2] ? MYID : {lfsr[7:6], lfsr[1:0]};
      step(lfsr[3] | lfsr[9], int'(lfsr[12:9]) % 10, s,
           {12'h770, 1'b0, lfsr[5], lfsr[8], lfsr[4]} ^ {lfsr[15], 15'h0}, lfsr[11],
           "R4 R5 R6 R7 R8 random mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule